// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block merges three reset causes into a single system reset. The causes are a supply-good flag from an external comparator, an active-low manual reset pin, and a watchdog that a processor services by toggling a kick pin. Any active cause puts the output in the detection (reset) state. The output leaves that state only after a programmable release delay has passed with no cause present.

The watchdog measures time in released operation. Either edge of the kick pin restarts it. If it expires, it forces a reset of one release delay and then starts again from zero. After an accepted kick edge, a short blanking window ignores any further edges, so that glitches on the kick pin cannot service the watchdog.

All timing comes from a prescaled tick. The release delay and the watchdog timeout are each picked by a 3-bit code from a fixed menu. The menu is expressed in units of 3.125 ms, each unit being `TICKS_PER_UNIT` ticks. The output polarity is a build parameter. The configuration must keep the release delay no longer than the watchdog timeout.

Top module: `reset_supervisor`

## Requirements
- R1: Synchronous reset puts the output in the detection state. After `rst` falls, with supply good and manual reset high, the output is released one release delay later.
- R2: When `supply_ok` falls, the output enters detection exactly 3 clock edges later (two synchronizer stages plus the state register).
- R3: Once every cause is gone, the output stays in detection for D ticks of the release delay and is then released. Counted from the input change, this takes between (D-1)·CLKS_PER_TICK+2 and D·CLKS_PER_TICK+4 clocks.
- R4: A low level on `mr_n` forces detection 3 clocks after the falling edge and holds it for as long as the pin stays low. After the pin returns high, the full release delay applies.
- R5: `dly_code` picks the release delay in units of 3.125 ms: 0→1, 1→8, 2→16, 3→32, 4→64, 5→128, 6→512. Code 7 is invalid and falls back to 512.
- R6: `wd_code` picks the watchdog timeout in units: 1→2, 2→16, 3→32, 4→64, 5→128, 6→512. Code 7 falls back to 512.
- R7: With `wd_code` = 0 the watchdog never forces a reset, however long the kick pin stays idle.
- R8: Both rising and falling edges of `kick` restart the watchdog. A kick level held steady for a whole timeout period causes an expiry.
- R9: On expiry the output enters detection for one release delay and is then released. The watchdog then restarts from zero, so a second expiry follows one full timeout later.
- R10: After an accepted kick edge, further edges are ignored for BLANK_TICKS ticks. An edge after that window is accepted again.
- R11: The watchdog count is held at zero while the output is in detection for any cause, and counting starts only at release.
- R12: With ACTIVE_HIGH = 0 the output is low in detection. With ACTIVE_HIGH = 1 it is high in detection. The two builds always give complementary outputs for the same inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Asynchronous supply-good flag from the comparator, high when good |
| mr_n | input | 1 | Asynchronous manual reset, active low |
| kick | input | 1 | Asynchronous watchdog kick; either edge services the watchdog |
| wd_code | input | 3 | Watchdog timeout select; 0 turns the watchdog off |
| dly_code | input | 3 | Release delay select |
| rst_out | output | 1 | Reset output; polarity set by ACTIVE_HIGH |

## Verification
The bench sweeps every delay code and every watchdog code, measures each release and expiry in clock cycles, and checks it against a window derived from the tick arithmetic. A wrong entry in either table, or a missing fallback for code 7, shows up as a count outside its window.

Kicks are sent at a spacing that services the watchdog only if both edge directions count. A design that reacts to one edge only would reset during that stretch.

Edge pairs are placed inside and outside the blanking window. A design without blanking would survive the inside pairs, and one whose window never closes would reset on the outside pairs.

Each expiry is measured twice. This catches a watchdog that kept counting during detection, or did not restart from zero, because it would fire early after release.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    localparam int CODE_W    = 3;
    localparam int MAX_UNITS = 512;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic supply_ok;
        logic mr_n;
        logic kick;
    } raw_in_t;

    // Release delay in 3.125 ms units
    function automatic int unsigned release_units(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 8;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            3'd6:    return 512;
            default: return MAX_UNITS;
        endcase
    endfunction

    // Watchdog timeout in 3.125 ms units; code 0 means watchdog off
    function automatic int unsigned timeout_units(input logic [CODE_W-1:0] code);
        case (code)
            3'd0:    return 0;
            3'd1:    return 2;
            3'd2:    return 16;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            3'd6:    return 512;
            default: return MAX_UNITS;
        endcase
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int             W    = 1,
    parameter logic [W-1:0]   INIT = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= INIT;
            stage2 <= INIT;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/rsup_tick.sv
module rsup_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    pcnt <= '0;
                end else if (pcnt == PW'(DIV - 1)) begin
                    pcnt <= '0;
                end else begin
                    pcnt <= pcnt + PW'(1);
                end
            end

            assign tick = (pcnt == PW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/rsup_hold.sv
module rsup_hold
    import rsup_pkg::*;
#(
    parameter int TPU = 8,
    parameter int CW  = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              cause,
    input  logic [CODE_W-1:0] code,
    output logic              in_det
);
    hold_state_e   st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    always_comb len = CW'(release_units(code) * TPU);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else if (cause) begin
            st  <= ST_HOLD;
            cnt <= '0;
        end else if (st == ST_HOLD && tick) begin
            if (cnt + CW'(1) >= len) begin
                st  <= ST_RUN;
                cnt <= '0;
            end else begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign in_det = (st == ST_HOLD);
endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog
    import rsup_pkg::*;
#(
    parameter int TPU         = 8,
    parameter int CW          = 13,
    parameter int BLANK_TICKS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              kick_s,
    input  logic              hold,
    input  logic [CODE_W-1:0] code,
    output logic              fire,
    output logic [CW-1:0]     cnt_o
);
    localparam int BW = $clog2(BLANK_TICKS + 1);

    logic          kick_q;
    logic          kick_edge;
    logic          enabled;
    logic          accept;
    logic [BW-1:0] blank;
    logic [CW-1:0] cnt;
    logic [CW-1:0] len;

    always_comb begin
        len       = CW'(timeout_units(code) * TPU);
        enabled   = (code != '0);
        kick_edge = kick_s ^ kick_q;
        accept    = kick_edge && enabled && !hold && (blank == '0);
        fire      = enabled && !hold && tick && !accept && (cnt + CW'(1) >= len);
    end

    always_ff @(posedge clk) begin
        if (rst) kick_q <= 1'b0;
        else     kick_q <= kick_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blank <= '0;
        end else if (accept) begin
            blank <= BW'(BLANK_TICKS);
        end else if (tick && blank != '0) begin
            blank <= blank - BW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold || !enabled) begin
            cnt <= '0;
        end else if (accept || fire) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign cnt_o = cnt;
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
    import rsup_pkg::*;
#(
    parameter bit ACTIVE_HIGH    = 1'b0,
    parameter int CLKS_PER_TICK  = 3125,
    parameter int TICKS_PER_UNIT = 100,
    parameter int BLANK_TICKS    = 28
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_ok,
    input  logic       mr_n,
    input  logic       kick,
    input  logic [2:0] wd_code,
    input  logic [2:0] dly_code,
    output logic       rst_out
);
    localparam int      CW        = $clog2(MAX_UNITS * TICKS_PER_UNIT + 1);
    localparam raw_in_t SYNC_INIT = '{supply_ok: 1'b0, mr_n: 1'b1, kick: 1'b0};

    raw_in_t       raw_a;
    raw_in_t       raw_s;
    logic          tick;
    logic          sok_s;
    logic          mr_s;
    logic          wd_fire;
    logic          in_det;
    logic          cause;
    logic [CW-1:0] wd_cnt;

    always_comb begin
        raw_a.supply_ok = supply_ok;
        raw_a.mr_n      = mr_n;
        raw_a.kick      = kick;
    end

    rsup_sync #(.W($bits(raw_in_t)), .INIT(SYNC_INIT)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_a),
        .q   (raw_s)
    );

    assign sok_s = raw_s.supply_ok;
    assign mr_s  = raw_s.mr_n;

    rsup_tick #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    rsup_watchdog #(.TPU(TICKS_PER_UNIT), .CW(CW), .BLANK_TICKS(BLANK_TICKS)) u_wd (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .kick_s (raw_s.kick),
        .hold   (in_det),
        .code   (wd_code),
        .fire   (wd_fire),
        .cnt_o  (wd_cnt)
    );

    assign cause = !sok_s || !mr_s || wd_fire;

    rsup_hold #(.TPU(TICKS_PER_UNIT), .CW(CW)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cause  (cause),
        .code   (dly_code),
        .in_det (in_det)
    );

    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign rst_out = in_det;
        end else begin : g_pol_low
            assign rst_out = !in_det;
        end
    endgenerate
endmodule

// File: rtl/rsup_checker.sv
module rsup_checker #(
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          sok_s,
    input logic          mr_s,
    input logic          in_det,
    input logic          wd_fire,
    input logic [CW-1:0] wd_cnt,
    input logic [2:0]    wd_code
);
    assert_supply_detect_R2: assert property (@(posedge clk) disable iff (rst)
        !sok_s |=> in_det);

    assert_manual_detect_R4: assert property (@(posedge clk) disable iff (rst)
        !mr_s |=> in_det);

    assert_release_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(in_det) |-> $past(tick));

    assert_release_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(in_det) |-> $past(sok_s && mr_s && !wd_fire));

    assert_count_held_R11: assert property (@(posedge clk) disable iff (rst)
        $past(in_det) |-> (wd_cnt == '0));

    assert_wd_off_R7: assert property (@(posedge clk) disable iff (rst)
        (wd_code == 3'd0) |-> !wd_fire);

    assert_expiry_detect_R9: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> in_det);
endmodule

bind reset_supervisor rsup_checker #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .sok_s   (sok_s),
    .mr_s    (mr_s),
    .in_det  (in_det),
    .wd_fire (wd_fire),
    .wd_cnt  (wd_cnt),
    .wd_code (wd_code)
);

// File: tb/reset_supervisor_test.sv
module reset_supervisor_test;
    localparam int P     = 2;
    localparam int U     = 8;
    localparam int BLANK = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       supply_ok = 1'b1;
    logic       mr_n = 1'b1;
    logic       kick = 1'b0;
    logic [2:0] wd_code = 3'd0;
    logic [2:0] dly_code = 3'd0;
    logic       out_lo;
    logic       out_hi;

    int checks = 0;
    int errors = 0;
    int pol_bad = 0;

    always #2.5 clk = ~clk;

    reset_supervisor #(.ACTIVE_HIGH(1'b0), .CLKS_PER_TICK(P), .TICKS_PER_UNIT(U),
                       .BLANK_TICKS(BLANK)) uut (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n), .kick(kick),
        .wd_code(wd_code), .dly_code(dly_code), .rst_out(out_lo));

    reset_supervisor #(.ACTIVE_HIGH(1'b1), .CLKS_PER_TICK(P), .TICKS_PER_UNIT(U),
                       .BLANK_TICKS(BLANK)) uut_hi (
        .clk(clk), .rst(rst), .supply_ok(supply_ok), .mr_n(mr_n), .kick(kick),
        .wd_code(wd_code), .dly_code(dly_code), .rst_out(out_hi));

    wire det = ~out_lo;

    // R12: complementary builds, sampled every cycle
    always @(negedge clk) if (!rst && out_hi !== ~out_lo) pol_bad++;

    function automatic int rel_ticks(input int c);
        int u;
        case (c)
            0: u = 1;   1: u = 8;   2: u = 16;  3: u = 32;
            4: u = 64;  5: u = 128; default: u = 512;
        endcase
        return u * U;
    endfunction

    function automatic int wd_ticks(input int c);
        int u;
        case (c)
            1: u = 2;   2: u = 16;  3: u = 32;  4: u = 64;
            5: u = 128; default: u = 512;
        endcase
        return u * U;
    endfunction

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_rng(input string tag, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
        end
    endtask

    // count negedges until detection state equals lvl
    task automatic wait_det(input logic lvl, input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (det !== lvl && n < maxc);
    endtask

    // sample n cycles and count detections seen
    task automatic quiet(input int cyc, output int seen);
        seen = 0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (det) seen++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, actual running expected done");
        summary();
    end

    initial begin
        int n;
        int seen;
        int d;
        int t;

        repeat (4) @(negedge clk);
        check_eq("R1 reset detect low build", out_lo, 0);
        check_eq("R12 reset detect high build", out_hi, 1);
        rst = 1'b0;
        d = rel_ticks(0);
        wait_det(1'b0, d * P + 20, n);
        check_rng("R1 release after reset", n, (d - 1) * P + 2, d * P + 4);

        // R2 / R3 / R5: sweep release delay codes via supply
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            dly_code = 3'(c);
            supply_ok = 1'b0;
            wait_det(1'b1, 10, n);
            check_eq($sformatf("R2 supply detect latency code %0d", c), n, 3);
            repeat (5) @(negedge clk);
            supply_ok = 1'b1;
            d = rel_ticks(c);
            wait_det(1'b0, d * P + 20, n);
            check_rng($sformatf("R3 R5 release delay code %0d", c), n, (d - 1) * P + 2, d * P + 4);
        end

        // R4: manual reset
        @(negedge clk);
        dly_code = 3'd1;
        mr_n = 1'b0;
        wait_det(1'b1, 10, n);
        check_eq("R4 manual detect latency", n, 3);
        quiet(300, seen);
        check_eq("R4 held while pin low", seen, 300);
        @(negedge clk);
        mr_n = 1'b1;
        d = rel_ticks(1);
        wait_det(1'b0, d * P + 20, n);
        check_rng("R4 full delay after pin high", n, (d - 1) * P + 2, d * P + 4);

        // R6 / R9 / R11: sweep watchdog codes, no kicks
        for (int c = 1; c < 8; c++) begin
            @(negedge clk);
            dly_code = 3'd0;
            supply_ok = 1'b0;
            wd_code = 3'(c);
            wait_det(1'b1, 10, n);
            @(negedge clk);
            supply_ok = 1'b1;
            wait_det(1'b0, 200, n);
            t = wd_ticks(c);
            d = rel_ticks(0);
            wait_det(1'b1, t * P + 20, n);
            check_rng($sformatf("R6 R11 timeout code %0d", c), n, (t - 1) * P, t * P + 1);
            wait_det(1'b0, d * P + 20, n);
            check_rng($sformatf("R9 expiry hold code %0d", c), n, (d - 1) * P, d * P + 1);
            wait_det(1'b1, t * P + 20, n);
            check_rng($sformatf("R9 restart timeout code %0d", c), n, (t - 1) * P, t * P + 1);
        end

        // R8: both edges service the watchdog (timeout 32 cycles)
        @(negedge clk);
        wd_code = 3'd2;
        dly_code = 3'd0;
        wd_code = 3'd1;
        wait_det(1'b0, 200, n);
        seen = 0;
        for (int k = 0; k < 15; k++) begin
            int s;
            quiet(19, s);
            seen += s;
            @(negedge clk);
            if (det) seen++;
            kick = ~kick;
        end
        check_eq("R8 alternating edges keep released", seen, 0);
        wait_det(1'b1, 60, n);
        check_rng("R8 steady level expires", n, 30, 40);

        // R10: second edge inside the blanking window is ignored
        wait_det(1'b0, 200, n);
        kick = ~kick;
        repeat (4) @(negedge clk);
        kick = ~kick;
        wait_det(1'b1, 60, n);
        check_rng("R10 blanked edge ignored", n, 26, 33);

        // R10: edge after the window is accepted
        wait_det(1'b0, 200, n);
        kick = ~kick;
        quiet(16, seen);
        kick = ~kick;
        begin
            int s2;
            quiet(28, s2);
            seen += s2;
        end
        check_eq("R10 edge after window accepted", seen, 0);
        wait_det(1'b1, 60, n);
        check_rng("R10 expiry after accepted edge", n, 1, 40);

        // R7: watchdog off
        @(negedge clk);
        wd_code = 3'd0;
        wait_det(1'b0, 200, n);
        quiet(9000, seen);
        check_eq("R7 no expiry with code 0", seen, 0);

        check_eq("R12 polarity mismatches", pol_bad, 0);
        summary();
    end
endmodule